// File: doc/BRIEF.md
# Programmable Interrupt Controller Command Front End

This block is the programming and servicing core of an eight-input interrupt controller. A processor talks to it through a byte-wide port with a single address bit: writes to the even address carry the start-of-setup word and the two kinds of runtime command, and writes to the odd address carry the remaining setup words and, once setup is over, the input mask. The setup sequence is two to four words long; flags in its first word decide which later words are expected.

Once it is set up, the block latches requests from the eight inputs, by rising edge or by level. It keeps the mask and in-service registers and drives an interrupt output whenever an unmasked request outranks everything already in service. Input 0 has the highest priority. An acknowledge pulse returns a vector made of the programmed base and the granted level, and marks that level in service. The in-service bit is later cleared by an end-of-interrupt command, or cleared at once when automatic end-of-interrupt is on. Software can read back the mask, the request register or the in-service register, or it can poll instead of using the acknowledge pin.

Top module: `irq_cmd_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF on an odd-address read, the request and in-service registers are 0, int_o is 0, and the block accepts runtime commands and odd-address mask writes without a setup sequence.
- R2: An even-address write with data bit 4 set restarts setup from any state. It clears the mask, the in-service register, the latched requests and any pending poll, selects the request register for even reads, and stores data bits 3, 1 and 0 as trigger mode (1 = level), single mode (1 = single) and fourth-word flag. The next odd write supplies the vector base (its bits 7:3 kept).
- R3: After the base word, one odd word is consumed only when single mode is 0, and then one more odd word only when the fourth-word flag is 1. Setup words never reach the mask. The first odd write after setup ends loads the mask.
- R4: In level mode the request register follows the input lines directly. In edge mode a 0-to-1 change latches the request, which stays set after the line falls until the request is acknowledged.
- R5: int_o is 1 exactly when some request is unmasked (mask bit 0 = enabled) and has a lower index than every set in-service bit. Input 0 has the highest priority.
- R6: While inta_i is 1, vector_o equals the base bits 7:3 followed by the granted level in bits 2:0. On that clock edge the granted in-service bit is set and its edge latch is cleared. With no grant, vector_o carries level 7 and no state changes.
- R7: When bit 1 of the fourth setup word is 1 (automatic end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R8: An even write with bits 4:3 = 00 and bit 5 = 1 ends an interrupt. If bit 6 = 0 it clears the lowest-index set in-service bit; if bit 6 = 1 it clears the in-service bit selected by bits 2:0. With bit 5 = 0 the write has no effect.
- R9: An even write with bits 4:3 = 01 and bit 1 = 1 selects what even reads return: the in-service register when bit 0 = 1, the request register when bit 0 = 0. Odd reads always return the mask.
- R10: An even write with bits 4:3 = 01 and bit 2 = 1 arms a poll. The next even read returns bit 7 = request pending and bits 2:0 = its level (0x00 when nothing is pending). If a request is pending, that read acts as an acknowledge. Later even reads return the selected register again.
- R11: In edge mode int_o rises on the first clock edge that samples the input high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| addr_i | input | 1 | Port address bit (0 = even, 1 = odd) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current addr_i |
| irq_i | input | 8 | Interrupt request lines |
| int_o | output | 1 | Interrupt pending to the processor |
| inta_i | input | 1 | Acknowledge pulse, one cycle |
| vector_o | output | 8 | Vector, valid while inta_i is 1 |

## Verification
Writes take effect on the clock edge that ends their strobe cycle, so register readback is sampled in the cycle after. rdata_o and vector_o are combinational and are sampled in the same cycle as the read or acknowledge strobe, before the edge that applies its side effects. A level request raises int_o without waiting for a clock edge, while an edge request raises it one edge later. The bench drives on falling edges and samples two nanoseconds later or on the next falling edge, and it checks int_o both before and after the latching edge.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
  typedef enum logic [1:0] {
    SEQ_READY,
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE
  } seq_state_e;

  // even-address command select bits
  localparam int unsigned SETUP_BIT  = 4;
  localparam int unsigned CMD3_BIT   = 3;
  // runtime command fields
  localparam int unsigned EOI_BIT    = 5;
  localparam int unsigned SPEC_BIT   = 6;
  localparam int unsigned RDEN_BIT   = 1;
  localparam int unsigned RDSEL_BIT  = 0;
  localparam int unsigned POLL_BIT   = 2;
  // setup word fields
  localparam int unsigned NEED4_BIT  = 0;
  localparam int unsigned SINGLE_BIT = 1;
  localparam int unsigned LEVEL_BIT  = 3;
  localparam int unsigned AUTO_BIT   = 1;
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [N-1:0]  oh_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    oh_o  = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        oh_o     = '0;
        oh_o[i]  = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/irq_init_seq.sv
module irq_init_seq
  import irq_cmd_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          restart_o,
  output logic          ready_o,
  output logic [DW-1:0] base_o,
  output logic          level_mode_o,
  output logic          auto_eoi_o
);
  seq_state_e state_q;
  logic       single_q, need4_q;

  assign restart_o = wr_i && !addr_i && wdata_i[SETUP_BIT];
  assign ready_o   = (state_q == SEQ_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= SEQ_READY;
      base_o       <= '0;
      level_mode_o <= 1'b0;
      auto_eoi_o   <= 1'b0;
      single_q     <= 1'b1;
      need4_q      <= 1'b0;
    end else if (restart_o) begin
      state_q      <= SEQ_BASE;
      level_mode_o <= wdata_i[LEVEL_BIT];
      single_q     <= wdata_i[SINGLE_BIT];
      need4_q      <= wdata_i[NEED4_BIT];
      auto_eoi_o   <= 1'b0;
    end else if (wr_i && addr_i) begin
      unique case (state_q)
        SEQ_BASE: begin
          base_o  <= {wdata_i[DW-1:LW], {LW{1'b0}}};
          state_q <= !single_q ? SEQ_CASC : (need4_q ? SEQ_MODE : SEQ_READY);
        end
        SEQ_CASC: state_q <= need4_q ? SEQ_MODE : SEQ_READY;
        SEQ_MODE: begin
          auto_eoi_o <= wdata_i[AUTO_BIT];
          state_q    <= SEQ_READY;
        end
        default: ;
      endcase
    end
  end

  // R2
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !ready_o);
endmodule

// File: rtl/irq_cmd_ctrl.sv
module irq_cmd_ctrl
  import irq_cmd_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned DW = N_IRQ,
  localparam int unsigned LW = $clog2(N_IRQ)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] irq_i,
  output logic          int_o,
  input  logic          inta_i,
  output logic [DW-1:0] vector_o
);
  logic          restart, ready, level_mode, auto_eoi;
  logic [DW-1:0] base;
  logic [DW-1:0] imr_q, isr_q, isr_d, edge_q, irq_q, irr;
  logic          rd_isr_q, poll_q;
  logic [DW-1:0] allowed, grant_oh, isr_oh;
  logic [LW-1:0] grant_idx, isr_idx;
  logic          grant_any, isr_any;
  logic          cmd2, cmd3, eoi_ns, eoi_sp, poll_rd, ack_fire;

  irq_init_seq #(.DW(DW), .LW(LW)) u_seq (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .restart_o(restart), .ready_o(ready), .base_o(base),
    .level_mode_o(level_mode), .auto_eoi_o(auto_eoi)
  );

  assign irr = level_mode ? irq_i : edge_q;

  // a level may win only if no in-service bit is at or above its priority
  for (genvar g = 0; g < DW; g++) begin : g_allow
    assign allowed[g] = ~|isr_q[g:0];
  end

  irq_first_set #(.N(DW)) u_grant (
    .vec_i(irr & ~imr_q & allowed), .oh_o(grant_oh),
    .idx_o(grant_idx), .any_o(grant_any)
  );

  irq_first_set #(.N(DW)) u_isr (
    .vec_i(isr_q), .oh_o(isr_oh), .idx_o(isr_idx), .any_o(isr_any)
  );

  assign cmd2    = wr_i && !addr_i && ready && !wdata_i[SETUP_BIT] && !wdata_i[CMD3_BIT];
  assign cmd3    = wr_i && !addr_i && ready && !wdata_i[SETUP_BIT] &&  wdata_i[CMD3_BIT];
  assign eoi_ns  = cmd2 && wdata_i[EOI_BIT] && !wdata_i[SPEC_BIT];
  assign eoi_sp  = cmd2 && wdata_i[EOI_BIT] &&  wdata_i[SPEC_BIT];
  assign poll_rd = rd_i && !addr_i && poll_q;
  assign ack_fire = (inta_i || poll_rd) && grant_any && ready;

  assign int_o    = grant_any;
  assign vector_o = {base[DW-1:LW], grant_any ? grant_idx : {LW{1'b1}}};

  always_comb begin
    if (addr_i)      rdata_o = imr_q;
    else if (poll_q) rdata_o = {grant_any, {(DW-1-LW){1'b0}}, grant_any ? grant_idx : {LW{1'b0}}};
    else if (rd_isr_q) rdata_o = isr_q;
    else             rdata_o = irr;
  end

  always_comb begin
    isr_d = isr_q;
    if (eoi_ns && isr_any) isr_d = isr_d & ~isr_oh;
    if (eoi_sp)            isr_d[wdata_i[LW-1:0]] = 1'b0;
    if (ack_fire && !auto_eoi) isr_d = isr_d | grant_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q    <= '1;
      isr_q    <= '0;
      edge_q   <= '0;
      irq_q    <= '0;
      rd_isr_q <= 1'b0;
      poll_q   <= 1'b0;
    end else begin
      irq_q <= irq_i;
      if (restart) begin
        imr_q    <= '0;
        isr_q    <= '0;
        edge_q   <= '0;
        rd_isr_q <= 1'b0;
        poll_q   <= 1'b0;
      end else begin
        isr_q  <= isr_d;
        edge_q <= (edge_q | (irq_i & ~irq_q)) & ~((ack_fire && !level_mode) ? grant_oh : '0);
        if (wr_i && addr_i && ready) imr_q <= wdata_i;
        if (cmd3 && wdata_i[RDEN_BIT]) rd_isr_q <= wdata_i[RDSEL_BIT];
        if (cmd3 && wdata_i[POLL_BIT]) poll_q <= 1'b1;
        else if (poll_rd)              poll_q <= 1'b0;
      end
    end
  end

  // R2
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (isr_q == '0) && (imr_q == '0));
  // R6
  ack_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && grant_any && ready && !auto_eoi && !wr_i) |=> ((isr_q & $past(grant_oh)) != '0));
  // R7
  auto_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && auto_eoi && !wr_i) |=> (isr_q == $past(isr_q)));
  // R6
  isr_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_q & ~$past(isr_q)) <= 1);
endmodule

// File: tb/irq_cmd_ctrl_tb.sv
module irq_cmd_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0, inta_i = 1'b0;
  logic [7:0] wdata_i = '0, irq_i = '0;
  logic [7:0] rdata_o, vector_o;
  logic       int_o;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_cmd_ctrl u_dut (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .irq_i, .int_o, .inta_i, .vector_o
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk_i); rd_i = 1'b1; addr_i = a;
    #2 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk_i); inta_i = 1'b1;
    #2 v = vector_o;
    @(negedge clk_i); inta_i = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk_i); irq_i = v;
    @(negedge clk_i); irq_i = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b1, d); check("R1 mask", d, 8'hFF);
    rd(1'b0, d); check("R1 request", d, 8'h00);
    check("R1 int", {7'b0, int_o}, 8'h00);
  endtask

  task automatic t_setup();
    logic [7:0] d;
    wr(1'b0, 8'h12); wr(1'b1, 8'h40);
    rd(1'b1, d); check("R2 mask cleared", d, 8'h00);
    wr(1'b1, 8'hF0); rd(1'b1, d); check("R3 mask load", d, 8'hF0);
    wr(1'b0, 8'h11); wr(1'b1, 8'h88); wr(1'b1, 8'h04);
    rd(1'b1, d); check("R3 cascade word skipped mask", d, 8'h00);
    wr(1'b1, 8'h01);
    rd(1'b1, d); check("R3 fourth word skipped mask", d, 8'h00);
    wr(1'b1, 8'h5A); rd(1'b1, d); check("R3 mask after setup", d, 8'h5A);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_edge_prio();
    logic [7:0] d;
    @(negedge clk_i); irq_i = 8'h24;
    #1 check("R11 not before edge", {7'b0, int_o}, 8'h00);
    @(negedge clk_i); irq_i = '0;
    check("R11 after edge", {7'b0, int_o}, 8'h01);
    rd(1'b0, d); check("R4 edge latch held", d, 8'h24);
    ack(d); check("R6 vector lvl2", d, 8'h8A);
    rd(1'b0, d); check("R6 latch cleared", d, 8'h20);
    wr(1'b0, 8'h0B); rd(1'b0, d); check("R9 isr read", d, 8'h04);
    check("R5 blocked by isr", {7'b0, int_o}, 8'h00);
    wr(1'b0, 8'h20);
    check("R8 nonspecific eoi", {7'b0, int_o}, 8'h01);
    ack(d); check("R6 vector lvl5", d, 8'h8D);
    wr(1'b0, 8'h63); rd(1'b0, d); check("R8 specific other level", d, 8'h20);
    wr(1'b0, 8'h05); rd(1'b0, d); check("R8 no eoi bit", d, 8'h20);
    wr(1'b0, 8'h65); rd(1'b0, d); check("R8 specific eoi", d, 8'h00);
    wr(1'b1, 8'h02); pulse(8'h02);
    check("R5 masked", {7'b0, int_o}, 8'h00);
    wr(1'b1, 8'h00);
    check("R5 unmasked", {7'b0, int_o}, 8'h01);
    ack(d); check("R6 vector lvl1", d, 8'h89);
    wr(1'b0, 8'h20);
    ack(d); check("R6 no grant vector", d, 8'h8F);
    rd(1'b0, d); check("R6 no grant isr", d, 8'h00);
  endtask

  task automatic t_level_auto();
    logic [7:0] d;
    wr(1'b0, 8'h1B); wr(1'b1, 8'h20); wr(1'b1, 8'h02);
    @(negedge clk_i); irq_i = 8'h08;
    @(negedge clk_i);
    check("R4 level int", {7'b0, int_o}, 8'h01);
    ack(d); check("R6 vector level mode", d, 8'h23);
    wr(1'b0, 8'h0B); rd(1'b0, d); check("R7 auto eoi isr", d, 8'h00);
    check("R4 level still pending", {7'b0, int_o}, 8'h01);
    @(negedge clk_i); irq_i = '0;
    @(negedge clk_i);
    check("R4 level follows line", {7'b0, int_o}, 8'h00);
  endtask

  task automatic t_poll();
    logic [7:0] d;
    wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h00);
    pulse(8'h40);
    wr(1'b0, 8'h0C); rd(1'b0, d); check("R10 poll byte", d, 8'h86);
    rd(1'b0, d); check("R10 back to request", d, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, d); check("R10 poll acked", d, 8'h40);
    wr(1'b0, 8'h20); rd(1'b0, d); check("R8 eoi after poll", d, 8'h00);
    wr(1'b0, 8'h0C); rd(1'b0, d); check("R10 empty poll", d, 8'h00);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    pulse(8'h04); ack(d);
    wr(1'b0, 8'h0B); rd(1'b0, d); check("R6 isr before restart", d, 8'h04);
    wr(1'b0, 8'h11); wr(1'b1, 8'h50);
    wr(1'b0, 8'h12); wr(1'b1, 8'h60); wr(1'b1, 8'h33);
    rd(1'b1, d); check("R2 restart mid setup", d, 8'h33);
    wr(1'b0, 8'h0B); rd(1'b0, d); check("R2 isr cleared", d, 8'h00);
    pulse(8'h04); ack(d); check("R2 new base", d, 8'h62);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_setup();
    t_edge_prio();
    t_level_auto();
    t_poll();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog got=00 exp=01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule